// File: doc/BRIEF.md
# Dual-Edge Two-Channel Conversion Result Multiplexer

This block sits behind a pair of pipelined converters whose results are taken together on each rising clock edge, one per channel. Both results go through a fixed-depth delay line. They then leave on a single shared data bus at twice the clock rate. The channel A result is driven after a rising edge and the channel B result after the following falling edge. A channel flag follows that rhythm so that downstream logic can tell the two apart. The output coding is chosen at run time: offset binary or two's complement.

The sample stream has no back-pressure and no valid/ready pair. The converters produce one pair per clock and the bus takes it unconditionally. The only way to stop the stream is the power-down or sleep input. Either one, seen high at a rising edge, freezes the delay line and the output registers, so the bus keeps showing its last value and the flag stops toggling. Pairs presented while frozen are dropped. A separate disable input releases the bus (high-impedance request) without disturbing any state.

Top module: `dual_edge_adc_mux`

## Requirements
- R1: Both channel codes are captured at the same rising edge. A rising edge is active when both pwr_down and sleep are low at that edge.
- R2: A pair captured at active rising edge n has its channel A result on bus_data right after active rising edge n+5, with chan_flag = 1.
- R3: The channel B result of that pair is on bus_data right after the falling edge that follows active edge n+5, with chan_flag = 0.
- R4: chan_flag is 1 from an active rising edge to the next falling edge and 0 at all other times. It is always 0 just before a rising edge.
- R5: twos_sel, sampled at the rising edge that loads a pair onto the output, picks the coding of both halves of that pair. When twos_sel is 0 the code passes unchanged (offset binary). When twos_sel is 1 bit 9 (the MSB) is inverted and bits 8..0 pass unchanged (two's complement).
- R6: bus_drive equals the inverse of out_disable at all times, with no clock delay. out_disable has no effect on bus_data or chan_flag.
- R7: A rising edge with pwr_down high changes neither bus_data nor chan_flag and does not advance the delay line. After release, results continue in capture order.
- R8: A rising edge with sleep high behaves the same way. Codes presented at such edges are never output.
- R9: When a freeze input rises after an active rising edge, the falling edge of that same cycle still presents the channel B result.
- R10: During reset bus_data and chan_flag are 0. The delay line starts with zero codes, so the first five active edges present code 0 in the selected coding (0x200 in two's complement).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; both edges used at the output |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_a_code | input | 10 | Channel A offset-binary conversion code |
| chan_b_code | input | 10 | Channel B offset-binary conversion code |
| twos_sel | input | 1 | 0: offset binary output, 1: two's complement output |
| out_disable | input | 1 | 1 releases the shared bus (high-impedance request) |
| pwr_down | input | 1 | Power-down: freezes pipeline and outputs |
| sleep | input | 1 | Sleep: both channels stop, outputs hold |
| bus_data | output | 10 | Shared data bus, A after rise, B after fall |
| bus_drive | output | 1 | 1 when the bus should be driven |
| chan_flag | output | 1 | 1 while channel A data is on the bus |

## Verification
The interleaving is tried with directed extreme codes (all zeros, all ones, and the values either side of mid-scale) under both codings. These separate an MSB-only inversion from any wider change and show whether the A and B lanes are swapped. Long random streams follow, with the coding flipping now and then and freeze pulses of one to four cycles from either power-down or sleep. These expose an off-by-one latency, a frozen stage that still advances, or dropped pairs that leak out later. Freezes that start just after an active edge show that the pending channel B half still completes. Random toggling of the disable input, including during freezes, shows that it moves only bus_drive.

// File: rtl/adcmux_pkg.sv
`timescale 1ns/1ps
package adcmux_pkg;
  localparam int DEFAULT_CODE_W  = 10;
  localparam int DEFAULT_LATENCY = 5;

  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } code_mode_e;
endpackage

// File: rtl/adcmux_sample_pipe.sv
`timescale 1ns/1ps
module adcmux_sample_pipe #(
  parameter int W     = 10,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0][W-1:0] a_stg;
  logic [DEPTH-1:0][W-1:0] b_stg;

  // Both lanes shift together on every active rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_stg <= '0;
      b_stg <= '0;
    end else if (advance) begin
      a_stg[0] <= a_in;
      b_stg[0] <= b_in;
      for (int i = 1; i < DEPTH; i++) begin
        a_stg[i] <= a_stg[i-1];
        b_stg[i] <= b_stg[i-1];
      end
    end
  end

  assign a_out = a_stg[LAST];
  assign b_out = b_stg[LAST];
endmodule

// File: rtl/adcmux_code_format.sv
`timescale 1ns/1ps
module adcmux_code_format
  import adcmux_pkg::*;
#(
  parameter int W = 10
) (
  input  code_mode_e   mode,
  input  logic [W-1:0] raw,
  output logic [W-1:0] coded
);
  localparam int MSB = W - 1;

  generate
    if (W == 1) begin : g_single
      assign coded = raw ^ (mode == CODE_TWOS);
    end else begin : g_multi
      // Offset binary to two's complement: only the sign position flips.
      assign coded = {raw[MSB] ^ (mode == CODE_TWOS), raw[MSB-1:0]};
    end
  endgenerate
endmodule

// File: rtl/adcmux_edge_interleaver.sv
`timescale 1ns/1ps
module adcmux_edge_interleaver #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] bus_data,
  output logic         chan_flag
);
  logic [W-1:0] a_q;
  logic [W-1:0] b_pend;
  logic [W-1:0] b_q;
  logic         rise_tgl;
  logic         fall_tgl;
  logic         phase_a;

  // Rising domain: load the pair and mark a new A phase by toggling.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_pend   <= '0;
      rise_tgl <= 1'b0;
    end else if (load) begin
      a_q      <= a_in;
      b_pend   <= b_in;
      rise_tgl <= ~rise_tgl;
    end
  end

  // Falling domain: complete a pending B half, then close the A phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q      <= '0;
      fall_tgl <= 1'b0;
    end else begin
      if (rise_tgl != fall_tgl) begin
        b_q <= b_pend;
      end
      fall_tgl <= rise_tgl;
    end
  end

  assign phase_a   = rise_tgl ^ fall_tgl;
  assign chan_flag = phase_a;
  assign bus_data  = phase_a ? a_q : b_q;
endmodule

// File: rtl/dual_edge_adc_mux.sv
`timescale 1ns/1ps
module dual_edge_adc_mux
  import adcmux_pkg::*;
#(
  parameter int CODE_W  = DEFAULT_CODE_W,
  parameter int LATENCY = DEFAULT_LATENCY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] chan_a_code,
  input  logic [CODE_W-1:0] chan_b_code,
  input  logic              twos_sel,
  input  logic              out_disable,
  input  logic              pwr_down,
  input  logic              sleep,
  output logic [CODE_W-1:0] bus_data,
  output logic              bus_drive,
  output logic              chan_flag
);
  // The output register adds one rising edge after the delay line.
  localparam int PIPE_DEPTH = LATENCY;

  logic              freeze;
  logic              active;
  code_mode_e        mode;
  logic [CODE_W-1:0] a_late;
  logic [CODE_W-1:0] b_late;
  logic [CODE_W-1:0] a_coded;
  logic [CODE_W-1:0] b_coded;

  assign freeze = pwr_down | sleep;
  assign active = ~freeze;
  assign mode   = code_mode_e'(twos_sel);

  adcmux_sample_pipe #(.W(CODE_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (active),
    .a_in    (chan_a_code),
    .b_in    (chan_b_code),
    .a_out   (a_late),
    .b_out   (b_late)
  );

  adcmux_code_format #(.W(CODE_W)) u_fmt_a (
    .mode  (mode),
    .raw   (a_late),
    .coded (a_coded)
  );

  adcmux_code_format #(.W(CODE_W)) u_fmt_b (
    .mode  (mode),
    .raw   (b_late),
    .coded (b_coded)
  );

  adcmux_edge_interleaver #(.W(CODE_W)) u_ilv (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (active),
    .a_in      (a_coded),
    .b_in      (b_coded),
    .bus_data  (bus_data),
    .chan_flag (chan_flag)
  );

  assign bus_drive = ~out_disable;
endmodule

// File: rtl/adcmux_checker.sv
`timescale 1ns/1ps
module adcmux_checker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_down,
  input logic         sleep,
  input logic [W-1:0] bus_data,
  input logic         chan_flag
);
  logic last_rise_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_rise_active <= 1'b0;
    else        last_rise_active <= ~(pwr_down | sleep);
  end

  // R4: the A phase has always closed before the next rising edge
  assert_flag_low_at_rise_R4: assert property (
    @(posedge clk) disable iff (!rst_n) !chan_flag);

  // R2: just before a falling edge the flag reports whether the last rise loaded A
  assert_flag_after_rise_R2: assert property (
    @(negedge clk) disable iff (!rst_n) chan_flag == last_rise_active);

  // R7: a power-down edge leaves the bus untouched
  assert_pd_holds_bus_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
      pwr_down |=> ($stable(bus_data) && $stable(chan_flag)));

  // R8: a sleep edge leaves the bus untouched and the flag low
  assert_sleep_holds_bus_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(bus_data) && !chan_flag));
endmodule

bind dual_edge_adc_mux adcmux_checker #(.W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_down  (pwr_down),
  .sleep     (sleep),
  .bus_data  (bus_data),
  .chan_flag (chan_flag)
);

// File: tb/tb_dual_edge_adc_mux.sv
`timescale 1ns/1ps
module tb_dual_edge_adc_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] chan_a_code = '0;
  logic [9:0] chan_b_code = '0;
  logic       twos_sel = 1'b0;
  logic       out_disable = 1'b0;
  logic       pwr_down = 1'b0;
  logic       sleep = 1'b0;
  logic [9:0] bus_data;
  logic       bus_drive;
  logic       chan_flag;

  int checks = 0;
  int errors = 0;
  int act_cnt = 0;
  bit done = 0;
  logic [9:0] ring_a [8];
  logic [9:0] ring_b [8];
  logic [9:0] last_b = '0;

  dual_edge_adc_mux dut (
    .clk(clk), .rst_n(rst_n), .chan_a_code(chan_a_code), .chan_b_code(chan_b_code),
    .twos_sel(twos_sel), .out_disable(out_disable), .pwr_down(pwr_down), .sleep(sleep),
    .bus_data(bus_data), .bus_drive(bus_drive), .chan_flag(chan_flag)
  );

  always #2.5 clk = ~clk;

  function automatic logic [9:0] fmt(logic [9:0] v, logic tc);
    return tc ? {~v[9], v[8:0]} : v;
  endfunction

  task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  // One clock: model the rising edge, drive next inputs, check both halves.
  task automatic run_cycle(logic [9:0] a, logic [9:0] b, logic tc, logic dis,
                           logic pd, logic sl);
    logic was_active;
    logic [9:0] exp_a;
    logic [9:0] exp_b;
    int sidx;
    @(posedge clk);
    was_active = !(pwr_down | sleep);
    if (was_active) begin
      ring_a[act_cnt % 8] = chan_a_code;
      ring_b[act_cnt % 8] = chan_b_code;
      act_cnt++;
      sidx = (act_cnt + 2) % 8;
      exp_a = fmt(ring_a[sidx], twos_sel);
      exp_b = fmt(ring_b[sidx], twos_sel);
    end else begin
      exp_a = last_b;
      exp_b = last_b;
    end
    #1;
    chan_a_code = a; chan_b_code = b; twos_sel = tc;
    out_disable = dis; pwr_down = pd; sleep = sl;
    #1;
    if (was_active) begin
      chk(act_cnt <= 5 ? "R10 zero fill" : (twos_sel ? "R2 R5 A half" : "R1 R2 A half"),
          bus_data, exp_a);
      chk("R4 flag after rise", chan_flag, 1'b1);
    end else begin
      chk(pwr_down ? "R7 frozen A slot" : "R8 frozen A slot", bus_data, exp_a);
      chk("R4 flag frozen", chan_flag, 1'b0);
    end
    chk("R6 drive", bus_drive, !out_disable);
    #2;
    chk(was_active && (pd | sl) ? "R9 B completes" : "R1 R3 B half", bus_data, exp_b);
    chk("R4 flag after fall", chan_flag, 1'b0);
    chk("R6 drive", bus_drive, !out_disable);
    last_b = exp_b;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] dir [6];
    int hold_left;
    logic hold_pd;
    logic tc_r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      ring_a[i] = '0;
      ring_b[i] = '0;
    end
    dir[0] = 10'h000; dir[1] = 10'h3FF; dir[2] = 10'h200;
    dir[3] = 10'h1FF; dir[4] = 10'h155; dir[5] = 10'h2AA;
    // Reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R10 reset bus", bus_data, 10'h000);
    chk("R10 reset flag", chan_flag, 1'b0);
    #2;
    chk("R10 reset bus fall", bus_data, 10'h000);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    twos_sel = 1'b1;
    // Directed extremes, two's complement then offset binary
    for (int k = 0; k < 12; k++) run_cycle(dir[k % 6], dir[5 - (k % 6)], 1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) run_cycle(dir[k % 6], dir[(k + 2) % 6], 1'b0, 1'b0, 1'b0, 1'b0);
    // Directed freeze right after an active edge, with disable toggled
    run_cycle(10'h123, 10'h321, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cycle(10'h0AA, 10'h0BB, 1'b0, 1'b1, 1'b1, 1'b0);
    run_cycle(10'h0CC, 10'h0DD, 1'b0, 1'b0, 1'b0, 1'b1);
    run_cycle(10'h0EE, 10'h0FF, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) run_cycle(10'h300 + k[9:0], 10'h010 + k[9:0], 1'b1, 1'b0, 1'b0, 1'b0);
    // Random stream
    hold_left = 0;
    hold_pd = 1'b0;
    tc_r = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (($urandom % 40) == 0) tc_r = ~tc_r;
      if (hold_left > 0) hold_left--;
      else if (($urandom % 20) == 0) begin
        hold_left = 1 + int'($urandom % 4);
        hold_pd = $urandom % 2 == 0;
      end
      run_cycle(10'($urandom), 10'($urandom), tc_r, ($urandom % 8) == 0,
                hold_left > 0 && hold_pd, hold_left > 0 && !hold_pd);
    end
    for (int k = 0; k < 8; k++) run_cycle(10'h000, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule